// File: doc/BRIEF.md
# Fractional Microsecond Timebase Counter

This block keeps a free-running microsecond count for software to read as a monotonic clocksource. The oscillator that clocks it may run at any rate, including rates that are not a whole number of megahertz. A configuration register holds a ratio of two small integers: a numerator and a denominator. A fractional rate generator adds the numerator to an accumulator on every clock. It emits a tick whenever the accumulator reaches the denominator, and then takes the denominator away. The ticks therefore average exactly numerator/denominator per clock. With the ratio set to one over the oscillator frequency in MHz, that gives one tick per microsecond.

Each tick advances an up counter that wraps at its full width. The same tick leaves the block as a one-cycle pulse, for use by neighbouring interval timers. A freeze register stops the count. While the freeze is set, the accumulator is held at zero, so counting resumes from a clean phase once the freeze is released. Register access is through a simple single-cycle bus: writes take effect on the clock edge, and reads are combinational from the address. Typical configuration values are 0x000B for a 12 MHz oscillator, 0x000C for 13 MHz, 0x0019 for 26 MHz and 0x045F for 19.2 MHz (5/96).

Top module: `utb_timebase`

## Requirements
- R1: The configuration register sits at offset 0x14. It is readable and writable through wdata[15:0], its bits 31:16 read as 0, and it resets to 0x000B.
- R2: The numerator is cfg[15:8]+1 and the denominator is cfg[7:0]+1. When the numerator is smaller than the denominator, the numerator is added to the accumulator on each clock. A tick occurs when the sum is at least the denominator, and the denominator is then subtracted. For example, 0x000B gives one tick every 12 clocks and 0x045F gives 5 ticks every 96 clocks.
- R3: The counter reads at offset 0x10 as a CNT_W-bit value, zero-extended to 32 bits. It resets to 0, advances by exactly one per tick, wraps from all ones to 0, and ignores bus writes.
- R4: tick_o is high for exactly the one cycle in which a new counter value is first visible on a read.
- R5: When the numerator is greater than or equal to the denominator, a tick occurs on every clock and the accumulator stays at 0.
- R6: The freeze register sits at offset 0x4C, bit 0. It resets to 0 and its other bits read as 0. While it is set, the counter holds, tick_o stays low and the accumulator is cleared. After release, the first tick comes after ceil(den/num) clocks.
- R7: A write to the configuration register clears the accumulator and allows no tick on that edge. The new ratio governs from the next edge onward.
- R8: Reads from unmapped offsets return 0, and writes to them change nothing.
- R9: After reset, the counter reads 0 and tick_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_o | output | 1 | One-cycle microsecond tick pulse |

## Verification
The bench builds the block with CNT_W=10. With that width, the counter wraps within about a thousand clocks at the 1/1 ratio, so the R3 wrap is exercised rather than left out of reach. The address and field widths stay at their defaults, so the four oscillator settings, including the 5/96 ratio, run with their real numerators and denominators. A behavioural model recomputes the accumulator, the count and the tick on every clock and is compared against the outputs at each falling edge.

// File: rtl/utb_pkg.sv
`timescale 1ns/1ps
package utb_pkg;
  localparam int FIELD_W = 8;
  localparam int ACC_W   = FIELD_W + 1;
  localparam int BUS_W   = 32;
  localparam int CFG_W   = 2 * FIELD_W;

  typedef struct packed {
    logic             tick;
    logic [ACC_W-1:0] acc;
  } step_t;

  function automatic logic [ACC_W-1:0] ratio_num(input logic [CFG_W-1:0] cfg);
    return {1'b0, cfg[CFG_W-1:FIELD_W]} + 1'b1;
  endfunction

  function automatic logic [ACC_W-1:0] ratio_den(input logic [CFG_W-1:0] cfg);
    return {1'b0, cfg[FIELD_W-1:0]} + 1'b1;
  endfunction

  // One clock of the fractional generator; acc < den holds on entry.
  function automatic step_t frac_step(input logic [ACC_W-1:0] acc,
                                      input logic [ACC_W-1:0] num,
                                      input logic [ACC_W-1:0] den);
    step_t            r;
    logic [ACC_W-1:0] sum;
    sum = acc + num;
    if (num >= den) begin
      r.tick = 1'b1;
      r.acc  = '0;
    end else if (sum >= den) begin
      r.tick = 1'b1;
      r.acc  = sum - den;
    end else begin
      r.tick = 1'b0;
      r.acc  = sum;
    end
    return r;
  endfunction
endpackage

// File: rtl/utb_cfg_regs.sv
`timescale 1ns/1ps
module utb_cfg_regs
  import utb_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CFG_OFS = 'h14,
  parameter logic [ADDR_W-1:0] FRZ_OFS = 'h4C,
  parameter logic [CFG_W-1:0]  CFG_RST = 'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              frz_q,
  output logic              cfg_wr
);
  logic frz_wr;

  assign cfg_wr = wr && (addr == CFG_OFS);
  assign frz_wr = wr && (addr == FRZ_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      frz_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= wdata[CFG_W-1:0];
      if (frz_wr) frz_q <= wdata[0];
    end
  end
endmodule

// File: rtl/utb_frac_rate.sv
`timescale 1ns/1ps
module utb_frac_rate
  import utb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             frz,
  input  logic             clr,
  output logic             step_tick,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] num_o,
  output logic [ACC_W-1:0] den_o
);
  step_t nxt;

  assign num_o     = ratio_num(cfg);
  assign den_o     = ratio_den(cfg);
  assign nxt       = frac_step(acc_o, num_o, den_o);
  assign step_tick = nxt.tick && !frz && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_o <= '0;
    else if (frz || clr) acc_o <= '0;
    else                 acc_o <= nxt.acc;
  end
endmodule

// File: rtl/utb_up_counter.sv
`timescale 1ns/1ps
module utb_up_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             tick_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= inc;
      if (inc) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/utb_timebase.sv
`timescale 1ns/1ps
module utb_timebase
  import utb_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                CNT_W   = 32,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h10,
  parameter logic [ADDR_W-1:0] CFG_OFS = 'h14,
  parameter logic [ADDR_W-1:0] FRZ_OFS = 'h4C,
  parameter logic [CFG_W-1:0]  CFG_RST = 'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tick_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             frz_q;
  logic             cfg_wr;
  logic             step_tick;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] num;
  logic [ACC_W-1:0] den;
  logic [CNT_W-1:0] count;

  utb_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CFG_OFS(CFG_OFS),
    .FRZ_OFS(FRZ_OFS),
    .CFG_RST(CFG_RST)
  ) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .cfg_q (cfg_q),
    .frz_q (frz_q),
    .cfg_wr(cfg_wr)
  );

  utb_frac_rate rate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .frz      (frz_q),
    .clr      (cfg_wr),
    .step_tick(step_tick),
    .acc_o    (acc),
    .num_o    (num),
    .den_o    (den)
  );

  utb_up_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (step_tick),
    .count (count),
    .tick_q(tick_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CNT_OFS)      bus_rdata = BUS_W'(count);
    else if (bus_addr == CFG_OFS) bus_rdata = BUS_W'(cfg_q);
    else if (bus_addr == FRZ_OFS) bus_rdata = BUS_W'(frz_q);
  end
endmodule

// File: rtl/utb_timebase_chk.sv
`timescale 1ns/1ps
module utb_timebase_chk
  import utb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_o,
  input logic [CNT_W-1:0] count,
  input logic             frz_q,
  input logic             cfg_wr,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] num,
  input logic [ACC_W-1:0] den
);
  logic [CNT_W-1:0] cnt_plus;
  assign cnt_plus = count + 1'b1;

  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> count == $past(cnt_plus)); // R4
  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> tick_o); // R3
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |=> ($stable(count) && !tick_o)); // R6
  AST_FREEZE_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |=> acc == '0); // R6
  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc < den); // R2
  AST_CFG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (acc == '0 && !tick_o)); // R7
  AST_FAST_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (num >= den && !frz_q && !cfg_wr) |=> tick_o); // R5
endmodule

bind utb_timebase utb_timebase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .tick_o(tick_o),
  .count (count),
  .frz_q (frz_q),
  .cfg_wr(cfg_wr),
  .acc   (acc),
  .num   (num),
  .den   (den)
);

// File: tb/utb_timebase_tb_top.sv
`timescale 1ns/1ps
module utb_timebase_tb_top;
  localparam int CNT_W = 10;
  localparam int CNT_M = 1 << CNT_W;
  localparam logic [7:0] A_CNT = 8'h10;
  localparam logic [7:0] A_CFG = 8'h14;
  localparam logic [7:0] A_FRZ = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = A_CNT;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_o;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int m_cnt, m_acc, m_cfg, m_frz, m_tick;
  int since_rst;

  always #4 clk = ~clk;

  utb_timebase #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_o(tick_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_cfg = 'h000B; m_frz = 0; m_tick = 0;
      since_rst = 0;
    end else begin
      int num, den, t;
      num = ((m_cfg >> 8) & 255) + 1;
      den = (m_cfg & 255) + 1;
      t = 0;
      if (m_frz != 0) m_acc = 0;
      else if (num >= den) begin t = 1; m_acc = 0; end
      else begin
        m_acc = m_acc + num;
        if (m_acc >= den) begin m_acc = m_acc - den; t = 1; end
      end
      if (bus_wr && bus_addr == A_CFG) begin m_acc = 0; t = 0; m_cfg = bus_wdata & 'hFFFF; end
      if (bus_wr && bus_addr == A_FRZ) m_frz = bus_wdata & 1;
      if (t != 0) m_cnt = (m_cnt + 1) % CNT_M;
      m_tick = t;
      since_rst = since_rst + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] exp_rd;
      string tag;
      case (bus_addr)
        A_CNT:   begin exp_rd = 32'(m_cnt); tag = "R3 counter"; end
        A_CFG:   begin exp_rd = 32'(m_cfg); tag = "R1 config"; end
        A_FRZ:   begin exp_rd = 32'(m_frz); tag = "R6 freeze"; end
        default: begin exp_rd = 32'h0;      tag = "R8 unmapped"; end
      endcase
      if (since_rst == 0) tag = "R9 reset";
      check(tag, bus_rdata, exp_rd);
      check(since_rst == 0 ? "R9 reset tick" : "R4 tick", {31'b0, tick_o}, 32'(m_tick));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
  endtask

  task automatic peek(input logic [7:0] a, input int n);
    @(posedge clk); #2;
    bus_addr = a;
    repeat (n) @(posedge clk);
    #2 bus_addr = A_CNT;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3); #2 rst_n = 1'b1;
    // R9 reset state, R1 reset value, R6 freeze reset value
    peek(A_CFG, 2);
    peek(A_FRZ, 2);
    // R2 12 MHz setting: one tick per 12 clocks
    idle(600);
    // R2 19.2 MHz setting, 5/96, with R7 clear on write
    bus_write(A_CFG, 32'hFFFF_045F);
    peek(A_CFG, 2);
    idle(2000);
    // R2 13 MHz and 26 MHz
    bus_write(A_CFG, 32'h0000_000C);
    idle(300);
    bus_write(A_CFG, 32'h0000_0019);
    idle(300);
    // R6 freeze holds the counter, then release with a fresh phase
    bus_write(A_FRZ, 32'hFFFF_FFFF);
    peek(A_FRZ, 2);
    idle(200);
    bus_write(A_FRZ, 32'h0);
    idle(100);
    // R3 writes to the counter are ignored
    bus_write(A_CNT, 32'h0000_0155);
    idle(50);
    // R8 unmapped offset reads 0, write has no effect
    bus_write(8'h20, 32'hDEAD_BEEF);
    peek(8'h20, 3);
    peek(A_CFG, 2);
    // R5 numerator equal to denominator: tick every clock, R3 wrap
    bus_write(A_CFG, 32'h0000_0000);
    idle(1100);
    // R5 numerator above denominator
    bus_write(A_CFG, 32'h0000_0300);
    idle(100);
    // R7 back-to-back config writes
    bus_write(A_CFG, 32'h0000_0102);
    bus_write(A_CFG, 32'h0000_0102);
    idle(100);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule